// File: doc/BRIEF.md
# Periodic Rate Divider and Interrupt Flags

This block is the timing and interrupt core of a real-time clock. Each cycle of `clk_i` is one cycle of a 32.768 kHz time base. A 15-bit ripple-free divider counts those cycles, and a three-bit control field either runs it, clears it and holds it at zero, or freezes it. A four-bit rate code picks one divider stage. That one stage drives both the square-wave pin and the periodic event, so the two always run at the same rate. The divider also produces the once-per-second update tick and an update-in-progress window just before it.

The block also holds the interrupt flag byte. The flags are periodic, alarm and update-ended. Each is set by its event whatever its enable says. A read of the byte clears all of them. While a read is in progress the byte the host sees stays frozen, and any events that arrive are held back and posted when the read ends. The interrupt request is the OR of each flag ANDed with its enable. It appears as a drive-low enable for an open-drain pin. The enables are loaded from a small write port, and the active-low reset clears them.

Top module: `rtc_rate_irq`

## Requirements
- R1: For a rate code c from 3 to 15, the selected tap is divider stage c-2, which has a period of 2^(c-1) clock cycles (8.192 kHz down to 2 Hz). Code 0 gives no tap: the square wave stays low and no periodic event occurs.
- R2: Rate codes 1 and 2 select the same stages as codes 8 and 9 (256 Hz and 128 Hz).
- R3: The divider control `dv_i` works as follows. 3'b010 increments the count each cycle. 3'b11x clears the count and holds it at zero. Any other value freezes the count. `upd_tick_o` is high for one cycle whenever the count equals 2^14 while the divider is running. Its first pulse comes 16384 cycles (500 ms) after the control goes from 11x to 010, and later pulses come every 32768 cycles.
- R4: `uip_o` is high in the 8 cycles just before each tick (244 us). While `set_i` is 1, both `uip_o` and `upd_tick_o` are held low.
- R5: `regc_o` has this layout: bit 7 interrupt request, bit 6 periodic flag, bit 5 alarm flag, bit 4 update-ended flag, and bits 3..0 always 0. An event sets its flag whatever its enable says. The periodic flag is set on the clock edge after the selected tap rises.
- R6: While `regc_rd_i` is high, flag bits 6..4 do not change and new events are held. In the cycle after the read strobe falls, the flags take exactly the events held during the read, plus any event arriving in that cycle. Every flag that was set before the read is cleared.
- R7: Bit 7 of `regc_o` and `irq_drive_o` both equal (PF and PIE) or (AF and AIE) or (UF and UIE). They follow an enable change in the same cycle.
- R8: `rst_ni` low clears all four enables, all flags, the held events and the divider count.
- R9: `sqw_o` equals the selected tap while SQWE is 1, and is held low while SQWE is 0.
- R10: When `en_we_i` is high, the enables are loaded from `en_wdata_i` on the clock edge: bit 3 PIE, bit 2 AIE, bit 1 UIE, bit 0 SQWE.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | 32.768 kHz time base clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| dv_i | input | 3 | Divider control: run, hold or stop |
| rate_i | input | 4 | Rate code selecting the tap |
| set_i | input | 1 | Inhibits the update tick and UIP |
| en_we_i | input | 1 | Enable register write strobe |
| en_wdata_i | input | 4 | Enable write data {PIE,AIE,UIE,SQWE} |
| alarm_evt_i | input | 1 | Alarm event pulse |
| upd_done_evt_i | input | 1 | Update-ended event pulse |
| regc_rd_i | input | 1 | Flag byte read strobe, level during read |
| regc_o | output | 8 | Flag byte |
| irq_drive_o | output | 1 | High when the IRQ pin is pulled low |
| sqw_o | output | 1 | Square-wave output |
| uip_o | output | 1 | Update-in-progress status |
| upd_tick_o | output | 1 | One-cycle update transfer tick |

## Verification
The hardest case to reach from the ports is an event that arrives while a flag read is in progress. To produce it, the bench turns off the periodic source by selecting rate 0, holds the read strobe for several cycles, and fires an update-ended pulse in the middle of the read. It then checks that the byte stays frozen during the read and that only the held event appears once the read ends. The update window is also hard to reach because it lies 16376 cycles from a divider restart. The bench restarts the divider through the hold pattern, counts cycles to the exact edges of the window, and then crosses the next window with SET high. A behavioural model compares every output on every cycle.

// File: rtl/rtc_rate_pkg.sv
package rtc_rate_pkg;
  localparam int unsigned FLAG_N = 3;

  typedef struct packed {
    logic pie;
    logic aie;
    logic uie;
    logic sqwe;
  } en_t;

  typedef enum logic [1:0] {CHAIN_STOP, CHAIN_HOLD, CHAIN_RUN} chain_e;

  function automatic chain_e chain_mode(input logic [2:0] dv);
    if (dv == 3'b010)        return CHAIN_RUN;
    else if (dv[2:1] == 2'b11) return CHAIN_HOLD;
    else                     return CHAIN_STOP;
  endfunction
endpackage

// File: rtl/rtc_div_chain.sv
module rtc_div_chain
  import rtc_rate_pkg::*;
#(
  parameter int unsigned DIV_W   = 15,
  parameter int unsigned UIP_CYC = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [2:0]       dv_i,
  input  logic             set_i,
  output logic [DIV_W-1:0] cnt_o,
  output logic             uip_o,
  output logic             tick_o
);
  localparam int unsigned HALF_I = 1 << (DIV_W - 1);
  localparam logic [DIV_W-1:0] HALF   = DIV_W'(HALF_I);
  localparam logic [DIV_W-1:0] UIP_LO = DIV_W'(HALF_I - UIP_CYC);

  chain_e           mode;
  logic [DIV_W-1:0] cnt_q;

  assign mode = chain_mode(dv_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cnt_q <= '0;
    else begin
      unique case (mode)
        CHAIN_RUN:  cnt_q <= cnt_q + 1'b1;
        CHAIN_HOLD: cnt_q <= '0;
        default:    cnt_q <= cnt_q;
      endcase
    end
  end

  logic live;
  assign live   = (mode == CHAIN_RUN) && !set_i;
  assign uip_o  = live && (cnt_q >= UIP_LO) && (cnt_q < HALF);
  assign tick_o = live && (cnt_q == HALF);
  assign cnt_o  = cnt_q;

  // R3
  hold_clr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode == CHAIN_HOLD) |=> (cnt_q == '0));
  // R3
  stop_keep_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode == CHAIN_STOP) |=> $stable(cnt_q));
  // R3
  tick_single_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tick_o |=> !tick_o);
  // R4
  uip_lead_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick_o && !$past(tick_o) && $past(mode == CHAIN_RUN && !set_i)) |-> $past(uip_o));
endmodule

// File: rtl/rtc_tap_sel.sv
module rtc_tap_sel #(
  parameter int unsigned DIV_W  = 15,
  parameter int unsigned RATE_W = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [DIV_W-1:0]  cnt_i,
  input  logic [RATE_W-1:0] rate_i,
  input  logic              sqwe_i,
  output logic              sqw_o,
  output logic              pf_evt_o
);
  localparam int unsigned CODES     = 1 << RATE_W;
  localparam int unsigned ALIAS_TOP = 3;
  localparam int unsigned ALIAS_OFS = 5;
  localparam int unsigned BASE_OFS  = 2;

  logic [CODES-1:0] tap_vec;
  logic             tap, tap_q;

  for (genvar c = 0; c < CODES; c++) begin : g_tap
    if (c == 0) begin : g_off
      assign tap_vec[c] = 1'b0;
    end else if (c < ALIAS_TOP) begin : g_alias
      assign tap_vec[c] = cnt_i[c+ALIAS_OFS];
    end else begin : g_base
      assign tap_vec[c] = cnt_i[c-BASE_OFS];
    end
  end

  assign tap = tap_vec[rate_i];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) tap_q <= 1'b0;
    else         tap_q <= tap;
  end

  assign pf_evt_o = tap && !tap_q;
  assign sqw_o    = sqwe_i && tap;

  // R5
  pf_edge_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pf_evt_o |=> !pf_evt_o);
  // R9
  sqw_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($stable(cnt_i) && $stable(rate_i) && $stable(sqwe_i)) |-> $stable(sqw_o));
endmodule

// File: rtl/rtc_irq_flags.sv
module rtc_irq_flags
  import rtc_rate_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              en_we_i,
  input  logic [3:0]        en_wdata_i,
  input  logic [FLAG_N-1:0] evt_i,
  input  logic              rd_i,
  output logic [7:0]        regc_o,
  output logic              irq_o,
  output logic              sqwe_o
);
  en_t              en_q;
  logic [FLAG_N-1:0] flg_q, pend_q, en_mask;
  logic              rd_q, irqf;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_q   <= '0;
      flg_q  <= '0;
      pend_q <= '0;
      rd_q   <= 1'b0;
    end else begin
      rd_q <= rd_i;
      if (rd_i) begin
        pend_q <= pend_q | evt_i;
      end else if (rd_q) begin
        flg_q  <= pend_q | evt_i;
        pend_q <= '0;
      end else begin
        flg_q <= flg_q | evt_i;
      end
      if (en_we_i) en_q <= en_t'(en_wdata_i);
    end
  end

  assign en_mask = {en_q.pie, en_q.aie, en_q.uie};
  assign irqf    = |(flg_q & en_mask);
  assign regc_o  = {irqf, flg_q, 4'b0000};
  assign irq_o   = irqf;
  assign sqwe_o  = en_q.sqwe;

  // R6
  rd_freeze_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_i |=> $stable(flg_q));
  // R5
  pf_set_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (evt_i[2] && !rd_i) |=> flg_q[2]);
  // R8
  rst_clear_chk: assert property (@(posedge clk_i)
    !rst_ni |-> (en_q == '0 && flg_q == '0 && pend_q == '0 && !irq_o));
endmodule

// File: rtl/rtc_rate_irq.sv
module rtc_rate_irq
  import rtc_rate_pkg::*;
#(
  parameter int unsigned DIV_W   = 15,
  parameter int unsigned RATE_W  = 4,
  parameter int unsigned UIP_CYC = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [2:0]        dv_i,
  input  logic [RATE_W-1:0] rate_i,
  input  logic              set_i,
  input  logic              en_we_i,
  input  logic [3:0]        en_wdata_i,
  input  logic              alarm_evt_i,
  input  logic              upd_done_evt_i,
  input  logic              regc_rd_i,
  output logic [7:0]        regc_o,
  output logic              irq_drive_o,
  output logic              sqw_o,
  output logic              uip_o,
  output logic              upd_tick_o
);
  logic [DIV_W-1:0] cnt;
  logic             pf_evt, sqwe;

  rtc_div_chain #(.DIV_W(DIV_W), .UIP_CYC(UIP_CYC)) u_chain (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .dv_i   (dv_i),
    .set_i  (set_i),
    .cnt_o  (cnt),
    .uip_o  (uip_o),
    .tick_o (upd_tick_o)
  );

  rtc_tap_sel #(.DIV_W(DIV_W), .RATE_W(RATE_W)) u_tap (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .cnt_i    (cnt),
    .rate_i   (rate_i),
    .sqwe_i   (sqwe),
    .sqw_o    (sqw_o),
    .pf_evt_o (pf_evt)
  );

  rtc_irq_flags u_flags (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .en_we_i    (en_we_i),
    .en_wdata_i (en_wdata_i),
    .evt_i      ({pf_evt, alarm_evt_i, upd_done_evt_i}),
    .rd_i       (regc_rd_i),
    .regc_o     (regc_o),
    .irq_o      (irq_drive_o),
    .sqwe_o     (sqwe)
  );

  // R7
  irq_flag_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_drive_o |-> (regc_o[6:4] != 3'b000));
endmodule

// File: tb/rtc_rate_irq_tb.sv
module rtc_rate_irq_tb;
  localparam int CLK_P = 10;
  localparam int HALF  = 16384;
  localparam int FULL  = 32768;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [2:0] dv = 3'b000;
  logic [3:0] rate = 4'd0;
  logic       set = 1'b0, en_we = 1'b0, alarm = 1'b0, upd_done = 1'b0, rd = 1'b0;
  logic [3:0] en_wdata = 4'd0;
  logic [7:0] regc;
  logic       irq, sqw, uip, tick;

  int n_tests = 0, n_fail = 0;
  bit done = 0;

  always #(CLK_P/2) clk = ~clk;

  rtc_rate_irq u_dut (
    .clk_i(clk), .rst_ni(rst_n), .dv_i(dv), .rate_i(rate), .set_i(set),
    .en_we_i(en_we), .en_wdata_i(en_wdata), .alarm_evt_i(alarm),
    .upd_done_evt_i(upd_done), .regc_rd_i(rd), .regc_o(regc),
    .irq_drive_o(irq), .sqw_o(sqw), .uip_o(uip), .upd_tick_o(tick)
  );

  // behavioural reference
  int   m_cnt;
  bit   m_tap_q, m_rd_q;
  bit [2:0] m_flg, m_pend;
  bit [3:0] m_en;

  function automatic bit m_tap();
    int idx;
    if (rate == 0) return 1'b0;
    idx = (rate < 3) ? rate + 5 : rate - 2;
    return ((m_cnt >> idx) & 1) != 0;
  endfunction

  function automatic bit m_run();
    return dv == 3'b010;
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_cnt = 0; m_tap_q = 0; m_rd_q = 0; m_flg = 0; m_pend = 0; m_en = 0;
    end else begin
      bit tp;
      bit [2:0] ev;
      tp = m_tap();
      ev = {tp && !m_tap_q, alarm, upd_done};
      if (rd) m_pend = m_pend | ev;
      else if (m_rd_q) begin m_flg = m_pend | ev; m_pend = 0; end
      else m_flg = m_flg | ev;
      m_rd_q = rd;
      if (en_we) m_en = en_wdata;
      m_tap_q = tp;
      if (m_run()) m_cnt = (m_cnt + 1) % FULL;
      else if (dv[2:1] == 2'b11) m_cnt = 0;
    end
  end

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s act=%h exp=%h t=%0t", req, act, exp, $time);
    end
  endtask

  task automatic compare();
    bit irqf, live;
    irqf = |(m_flg & m_en[3:1]);
    live = m_run() && !set;
    check("R1/R2/R9 sqw", {7'd0, sqw}, {7'd0, m_en[0] & m_tap()});
    check("R5/R6/R7 regc", regc, {irqf, m_flg, 4'b0000});
    check("R7 irq", {7'd0, irq}, {7'd0, irqf});
    check("R4 uip", {7'd0, uip}, {7'd0, live && m_cnt >= HALF-8 && m_cnt < HALF});
    check("R3 tick", {7'd0, tick}, {7'd0, live && m_cnt == HALF});
  endtask

  task automatic cyc(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      compare();
    end
  endtask

  task automatic summary();
    if (!done) begin
      done = 1;
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  endtask

  initial begin
    #(CLK_P*190000);
    n_fail++;
    $display("FAIL watchdog expired");
    summary();
  end

  initial begin
    cyc(3);
    check("R8 reset regc", regc, 8'h00);
    check("R8 reset irq", {7'd0, irq}, 8'h00);
    check("R8 reset sqw", {7'd0, sqw}, 8'h00);
    rst_n = 1'b1;
    // R10 load all enables
    en_we = 1; en_wdata = 4'b1111; cyc(1); en_we = 0;
    dv = 3'b110; cyc(4);
    rate = 4'd3; dv = 3'b010;
    // R1 sweep every code
    for (int c = 3; c < 16; c++) begin
      rate = c[3:0];
      cyc((c < 12) ? (1 << c) : 4096);
      rd = 1; cyc(2); rd = 0;
    end
    // R2 aliases and code 0
    for (int k = 0; k < 5; k++) begin
      int codes[5] = '{1, 8, 2, 9, 0};
      rate = codes[k][3:0];
      cyc(1024);
    end
    // R6 read hold with events
    rd = 1; cyc(1); rd = 0; cyc(1);
    check("R1 code0 no flags", regc, 8'h00);
    alarm = 1; cyc(1); alarm = 0; cyc(1);
    check("R5 alarm flag", regc, 8'hA0);
    rd = 1; cyc(1); upd_done = 1; cyc(1); upd_done = 0; cyc(1);
    check("R6 frozen during read", regc, 8'hA0);
    rd = 0; cyc(1);
    check("R6 held event posted", regc, 8'h90);
    rd = 1; cyc(1); rd = 0; cyc(1);
    check("R6 read clears", regc, 8'h00);
    // R5 flag without enable, R7 and R10 late enable
    en_we = 1; en_wdata = 4'b0000; cyc(1); en_we = 0;
    alarm = 1; cyc(1); alarm = 0; cyc(1);
    check("R5 flag with enable off", regc, 8'h20);
    check("R7 no irq when disabled", {7'd0, irq}, 8'h00);
    en_we = 1; en_wdata = 4'b0100; cyc(1); en_we = 0;
    check("R10 AIE raises irq", {7'd0, irq}, 8'h01);
    rd = 1; cyc(1); rd = 0; cyc(1);
    // R3 first tick timing, R4 window edges
    en_we = 1; en_wdata = 4'b1111; cyc(1); en_we = 0;
    rate = 4'd15;
    dv = 3'b111; cyc(2);
    dv = 3'b010; cyc(HALF-9);
    check("R4 uip low before window", {7'd0, uip}, 8'h00);
    cyc(1);
    check("R4 uip at window start", {7'd0, uip}, 8'h01);
    cyc(7);
    check("R3 no tick at 16383", {7'd0, tick}, 8'h00);
    cyc(1);
    check("R3 first tick at 500ms", {7'd0, tick}, 8'h01);
    check("R4 uip low at tick", {7'd0, uip}, 8'h00);
    // R4 SET suppresses the next window and tick
    set = 1; cyc(FULL-4);
    check("R4 set keeps uip low", {7'd0, uip}, 8'h00);
    cyc(4);
    check("R4 set suppresses tick", {7'd0, tick}, 8'h00);
    set = 0; cyc(FULL);
    check("R3 tick one second later", {7'd0, tick}, 8'h01);
    // R3 stop freezes divider, R9 sqwe off
    rate = 4'd4; dv = 3'b000; cyc(40);
    dv = 3'b010; cyc(37);
    en_we = 1; en_wdata = 4'b1110; cyc(1); en_we = 0; cyc(20);
    check("R9 sqwe off holds low", {7'd0, sqw}, 8'h00);
    // R8 reset mid-run
    en_we = 1; en_wdata = 4'b1111; cyc(1); en_we = 0;
    alarm = 1; cyc(1); alarm = 0; rate = 4'd0; cyc(1);
    rst_n = 0; cyc(1);
    check("R8 reset clears flags", regc, 8'h00);
    check("R8 reset clears irq", {7'd0, irq}, 8'h00);
    rst_n = 1; rate = 4'd3; cyc(20);
    check("R8 sqwe cleared", {7'd0, sqw}, 8'h00);
    summary();
  end
endmodule